// File: doc/BRIEF.md
# Two-Port Parallel I/O Register Bank

This block holds the registers that a processor reaches over an 8-bit bus to run a two-port parallel I/O adapter. Each port (A and B) owns three registers: an output register, a direction register and a control register. Two register-select lines pick either a port's control register or that port's shared peripheral slot. Bit 2 of the port's own control register decides whether the slot reaches the output register or the direction register. A bus cycle counts only when the three chip-select lines carry their active pattern and the enable strobe is high.

Each pin is modelled as an input, an output value and an output enable. The output enable is the direction register. The two ports read back in different ways. Port A always returns the level seen at its pins. Port B returns the latched output value for output bits and the pin level for input bits. Control bits 0 to 5 can be written and are driven out for the handshake logic. Bits 6 and 7 are interrupt flags computed elsewhere, and the bus can only read them. A read of a port's output register produces a one-cycle strobe that the flag-clear logic uses.

Top module: `par_port_regs`

## Requirements
- R1: A bus cycle takes effect only when sel_a and sel_b are high and sel_n is low. Under any other pattern a write changes no register and a read does not raise bus_rdata_oe.
- R2: A write is an enabled, selected cycle with bus_rw low. The target register takes the value of bus_wdata at that clock edge, and the value is visible on the outputs from the next cycle.
- R3: A read is an enabled, selected cycle with bus_rw high. In the next cycle bus_rdata_oe is 1 and bus_rdata holds the read value. In every other cycle bus_rdata_oe is 0 and bus_rdata is 0.
- R4: reg_sel encodes the location as follows: 00 selects the port A slot, 01 selects control A, 10 selects the port B slot, 11 selects control B.
- R5: Within a port, control bit 2 steers the slot. A 1 reaches the output register and a 0 reaches the direction register, for both reads and writes.
- R6: a_pin_oe and b_pin_oe equal the direction registers, so a bit of 1 makes that pin an output. a_pin_o and b_pin_o equal the output registers.
- R7: A read of the port A output register returns a_pin_i on every bit, whatever the direction.
- R8: A read of the port B output register returns (output register AND direction) OR (b_pin_i AND NOT direction).
- R9: A control read returns the port's flag pair in bits 7:6 and the stored bits in 5:0. A write stores only bits 5:0, and bus_wdata[7:6] is ignored. a_ctrl and b_ctrl expose the stored bits 5:0.
- R10: A synchronous active-high rst clears every register, the read data, the read-data enable and both strobes to 0.
- R11: a_rd_strobe (b_rd_strobe) pulses for exactly one cycle, the cycle after a read of that port's slot made while its control bit 2 is 1. Direction-register reads, writes and control reads produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Bus enable strobe, one cycle per access |
| bus_rw | input | 1 | 1 = read, 0 = write |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| reg_sel | input | 2 | Location select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| bus_rdata_oe | output | 1 | Read data valid / drive enable |
| a_pin_i | input | DW | Port A pin levels |
| a_pin_o | output | DW | Port A output values |
| a_pin_oe | output | DW | Port A output enables |
| b_pin_i | input | DW | Port B pin levels |
| b_pin_o | output | DW | Port B output values |
| b_pin_oe | output | DW | Port B output enables |
| a_flags | input | 2 | Port A interrupt flags, read as control bits 7:6 |
| b_flags | input | 2 | Port B interrupt flags, read as control bits 7:6 |
| a_ctrl | output | 6 | Port A control bits 5:0 |
| b_ctrl | output | 6 | Port B control bits 5:0 |
| a_rd_strobe | output | 1 | Port A output-register read strobe |
| b_rd_strobe | output | 1 | Port B output-register read strobe |

## Verification
Every result is due one clock after the access cycle that causes it. That holds for read data and its enable, for the strobes, and for register contents seen on the pin and control outputs. Pin and flag inputs are sampled at the same edge as the read. The bench has a behavioural model that advances on the same rising edge using only the port inputs. All outputs are compared with the model at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int CTRL_W   = 8;
  localparam int CTRL_RW  = 6;
  localparam int ACC_BIT  = 2;
  localparam int NPORT    = 2;

  typedef enum logic [1:0] {
    LOC_SLOT_A = 2'b00,
    LOC_CTRL_A = 2'b01,
    LOC_SLOT_B = 2'b10,
    LOC_CTRL_B = 2'b11
  } loc_e;
endpackage

// File: rtl/pp_decode.sv
module pp_decode
  import pp_pkg::*;
(
  input  logic             bus_en,
  input  logic             bus_rw,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_n,
  input  logic [1:0]       reg_sel,
  output logic             rd_any,
  output logic [NPORT-1:0] wr_slot,
  output logic [NPORT-1:0] wr_ctrl,
  output logic [NPORT-1:0] rd_slot
);
  logic chosen;
  logic live;

  assign chosen = sel_a & sel_b & ~sel_n;
  assign live   = bus_en & chosen;
  assign rd_any = live & bus_rw;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit        = live & (reg_sel[1] == p[0]);
    assign wr_slot[p] = hit & ~bus_rw & ~reg_sel[0];
    assign wr_ctrl[p] = hit & ~bus_rw &  reg_sel[0];
    assign rd_slot[p] = hit &  bus_rw & ~reg_sel[0];
  end
endmodule

// File: rtl/pp_port.sv
module pp_port
  import pp_pkg::*;
#(
  parameter int DW         = 8,
  parameter bit LATCH_READ = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_slot,
  input  logic              wr_ctrl,
  input  logic              rd_slot,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     pin_i,
  input  logic [1:0]        flags_i,
  output logic [DW-1:0]     out_q,
  output logic [DW-1:0]     ddr_q,
  output logic [CTRL_RW-1:0] ctrl_q,
  output logic [DW-1:0]     slot_rd,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              rd_pulse
);
  logic          acc;
  logic [DW-1:0] port_view;

  assign acc = ctrl_q[ACC_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q    <= '0;
      ddr_q    <= '0;
      ctrl_q   <= '0;
      rd_pulse <= 1'b0;
    end else begin
      if (wr_slot && acc)  out_q  <= wdata;
      if (wr_slot && !acc) ddr_q  <= wdata;
      if (wr_ctrl)         ctrl_q <= wdata[CTRL_RW-1:0];
      rd_pulse <= rd_slot & acc;
    end
  end

  if (LATCH_READ) begin : g_latch_view
    assign port_view = (out_q & ddr_q) | (pin_i & ~ddr_q);
  end else begin : g_pin_view
    assign port_view = pin_i;
  end

  assign slot_rd = acc ? port_view : ddr_q;
  assign ctrl_rd = {flags_i, ctrl_q};

  assert_ddr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_slot || acc) |=> $stable(ddr_q));
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_slot || !acc) |=> $stable(out_q));
  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_q == '0 && ddr_q == '0 && ctrl_q == '0 && !rd_pulse));
endmodule

// File: rtl/par_port_regs.sv
module par_port_regs
  import pp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_en,
  input  logic               bus_rw,
  input  logic               sel_a,
  input  logic               sel_b,
  input  logic               sel_n,
  input  logic [1:0]         reg_sel,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rdata_oe,
  input  logic [DW-1:0]      a_pin_i,
  output logic [DW-1:0]      a_pin_o,
  output logic [DW-1:0]      a_pin_oe,
  input  logic [DW-1:0]      b_pin_i,
  output logic [DW-1:0]      b_pin_o,
  output logic [DW-1:0]      b_pin_oe,
  input  logic [1:0]         a_flags,
  input  logic [1:0]         b_flags,
  output logic [CTRL_RW-1:0] a_ctrl,
  output logic [CTRL_RW-1:0] b_ctrl,
  output logic               a_rd_strobe,
  output logic               b_rd_strobe
);
  logic             rd_any;
  logic [NPORT-1:0] wr_slot, wr_ctrl, rd_slot, pulse;

  logic [DW-1:0]      pin_i   [NPORT];
  logic [1:0]         flags   [NPORT];
  logic [DW-1:0]      out_q   [NPORT];
  logic [DW-1:0]      ddr_q   [NPORT];
  logic [CTRL_RW-1:0] ctrl_q  [NPORT];
  logic [DW-1:0]      slot_rd [NPORT];
  logic [CTRL_W-1:0]  ctrl_rd [NPORT];
  logic [DW-1:0]      rdata_d;

  pp_decode u_dec (
    .bus_en  (bus_en),
    .bus_rw  (bus_rw),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .sel_n   (sel_n),
    .reg_sel (reg_sel),
    .rd_any  (rd_any),
    .wr_slot (wr_slot),
    .wr_ctrl (wr_ctrl),
    .rd_slot (rd_slot)
  );

  assign pin_i[0] = a_pin_i;
  assign pin_i[1] = b_pin_i;
  assign flags[0] = a_flags;
  assign flags[1] = b_flags;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pp_port #(.DW(DW), .LATCH_READ(p == 1)) u_port (
      .clk      (clk),
      .rst      (rst),
      .wr_slot  (wr_slot[p]),
      .wr_ctrl  (wr_ctrl[p]),
      .rd_slot  (rd_slot[p]),
      .wdata    (bus_wdata),
      .pin_i    (pin_i[p]),
      .flags_i  (flags[p]),
      .out_q    (out_q[p]),
      .ddr_q    (ddr_q[p]),
      .ctrl_q   (ctrl_q[p]),
      .slot_rd  (slot_rd[p]),
      .ctrl_rd  (ctrl_rd[p]),
      .rd_pulse (pulse[p])
    );
  end

  assign a_pin_o     = out_q[0];
  assign a_pin_oe    = ddr_q[0];
  assign b_pin_o     = out_q[1];
  assign b_pin_oe    = ddr_q[1];
  assign a_ctrl      = ctrl_q[0];
  assign b_ctrl      = ctrl_q[1];
  assign a_rd_strobe = pulse[0];
  assign b_rd_strobe = pulse[1];

  always_comb begin
    if (reg_sel[0]) rdata_d = DW'(ctrl_rd[reg_sel[1]]);
    else            rdata_d = slot_rd[reg_sel[1]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      bus_rdata_oe <= 1'b0;
    end else begin
      bus_rdata    <= rd_any ? rdata_d : '0;
      bus_rdata_oe <= rd_any;
    end
  end

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !(sel_a && sel_b && !sel_n) |=> !bus_rdata_oe);
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_rdata_oe |-> bus_rdata == '0);
  assert_flag_read_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_rw && sel_a && sel_b && !sel_n && reg_sel == LOC_CTRL_A)
      |=> bus_rdata[7:6] == $past(a_flags));
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_rd_strobe, b_rd_strobe}));
  assert_strobe_with_data_R11: assert property (@(posedge clk) disable iff (rst)
    (a_rd_strobe || b_rd_strobe) |-> bus_rdata_oe);
  assert_strobe_once_R11: assert property (@(posedge clk) disable iff (rst)
    a_rd_strobe |=> !a_rd_strobe || $past(bus_en));
endmodule

// File: tb/par_port_regs_tb_top.sv
module par_port_regs_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 0, bus_rw = 0, sel_a = 0, sel_b = 0, sel_n = 1;
  logic [1:0] reg_sel = 0;
  logic [DW-1:0] bus_wdata = 0, a_pin_i = 0, b_pin_i = 0;
  logic [1:0] a_flags = 0, b_flags = 0;
  logic [DW-1:0] bus_rdata, a_pin_o, a_pin_oe, b_pin_o, b_pin_oe;
  logic bus_rdata_oe, a_rd_strobe, b_rd_strobe;
  logic [5:0] a_ctrl, b_ctrl;

  always #2 clk = ~clk;

  par_port_regs #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_rw(bus_rw),
    .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n), .reg_sel(reg_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .a_pin_i(a_pin_i), .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe),
    .b_pin_i(b_pin_i), .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe),
    .a_flags(a_flags), .b_flags(b_flags), .a_ctrl(a_ctrl), .b_ctrl(b_ctrl),
    .a_rd_strobe(a_rd_strobe), .b_rd_strobe(b_rd_strobe)
  );

  int tests = 0, fails = 0, cycles = 0;
  bit primed = 0, finished = 0;

  // behavioural reference: registers kept as plain integers
  int m_out[2], m_ddr[2], m_ctl[2];
  int m_rdata = 0, m_oe = 0, m_stb[2];

  always @(posedge clk) begin
    int idx, rv;
    bit live;
    if (rst) begin
      for (int p = 0; p < 2; p++) begin m_out[p] = 0; m_ddr[p] = 0; m_ctl[p] = 0; m_stb[p] = 0; end
      m_rdata = 0; m_oe = 0;
      primed = 1;
    end else begin
      live = bus_en && sel_a && sel_b && !sel_n;
      idx = reg_sel[1];
      m_stb[0] = 0; m_stb[1] = 0;
      m_rdata = 0; m_oe = 0;
      if (live && bus_rw) begin
        m_oe = 1;
        if (reg_sel[0]) rv = ((idx ? b_flags : a_flags) << 6) | m_ctl[idx];
        else if ((m_ctl[idx] >> 2) & 1) begin
          if (idx == 0) rv = a_pin_i;
          else rv = (m_out[1] & m_ddr[1]) | (b_pin_i & ~m_ddr[1] & 255);
          m_stb[idx] = 1;
        end else rv = m_ddr[idx];
        m_rdata = rv & 255;
      end
      if (live && !bus_rw) begin
        if (reg_sel[0]) m_ctl[idx] = bus_wdata & 63;
        else if ((m_ctl[idx] >> 2) & 1) m_out[idx] = bus_wdata;
        else m_ddr[idx] = bus_wdata;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (primed && !finished) begin
      chk("R3 R4 R5 R7 R8 R9", "bus_rdata", bus_rdata, m_rdata);
      chk("R1 R3", "bus_rdata_oe", bus_rdata_oe, m_oe);
      chk("R2 R6 R10", "a_pin_o", a_pin_o, m_out[0]);
      chk("R2 R6 R10", "a_pin_oe", a_pin_oe, m_ddr[0]);
      chk("R2 R6 R10", "b_pin_o", b_pin_o, m_out[1]);
      chk("R2 R6 R10", "b_pin_oe", b_pin_oe, m_ddr[1]);
      chk("R9 R10", "a_ctrl", a_ctrl, m_ctl[0]);
      chk("R9 R10", "b_ctrl", b_ctrl, m_ctl[1]);
      chk("R11", "a_rd_strobe", a_rd_strobe, m_stb[0]);
      chk("R11", "b_rd_strobe", b_rd_strobe, m_stb[1]);
    end
    if (cycles > 150000 && !finished) begin
      fails++;
      finished = 1;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // one bus cycle, driven at a falling edge, then the bus goes idle
  task automatic acc(input bit rw, input int loc, input int d, input bit [2:0] cs = 3'b110);
    @(negedge clk);
    bus_en = 1; bus_rw = rw; reg_sel = loc[1:0]; bus_wdata = d[7:0];
    {sel_a, sel_b, sel_n} = cs;
    @(negedge clk);
    bus_en = 0; {sel_a, sel_b, sel_n} = 3'b001;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                                   // R10 reset state compared by the model
    a_pin_i = 8'h3C; b_pin_i = 8'hA5; a_flags = 2'b10; b_flags = 2'b01;
    acc(0, 0, 8'hF0);                          // R5 access bit 0: slot is direction A
    acc(0, 1, 8'hFF);                          // R9 write ctrl A incl. bits 7:6 (ignored)
    acc(0, 0, 8'h5A);                          // R5 now output register A
    acc(1, 0, 0);                              // R7 pin level read, R11 strobe A
    acc(1, 1, 0);                              // R9 flags in 7:6
    acc(0, 2, 8'h0F);                          // R4 slot B -> direction B
    acc(0, 3, 8'h04);                          // R4 ctrl B access bit
    acc(0, 2, 8'h99);                          // R6 output register B
    acc(1, 2, 0);                              // R8 mixed latch/pin read, R11 strobe B
    acc(1, 3, 0);
    for (int c = 0; c < 8; c++) if (c != 6) acc(0, 2, 8'h11, c[2:0]); // R1 deselected writes
    for (int c = 0; c < 8; c++) if (c != 6) acc(1, 0, 0, c[2:0]);     // R1 deselected reads
    acc(0, 1, 8'h00);                          // back to direction A
    acc(1, 0, 0);                              // R11 no strobe on direction read
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      a_pin_i = $urandom; b_pin_i = $urandom;
      a_flags = $urandom; b_flags = $urandom;
      bus_en = $urandom; bus_rw = $urandom; reg_sel = $urandom;
      bus_wdata = $urandom;
      {sel_a, sel_b, sel_n} = ($urandom % 4 != 0) ? 3'b110 : 3'($urandom);
      if (i == 2000) rst = 1;                  // R10 mid-run reset
      if (i == 2003) rst = 0;
    end
    @(negedge clk); bus_en = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule